// File: doc/BRIEF.md
# Octant-Folded Sine/Cosine Generator

This block turns an unsigned phase word, which spans one full turn, into a pair of signed samples: the sine and the cosine of that phase. It holds a table for only the first eighth of a turn (0 to π/4). Each table entry stores both the sine and the cosine of its angle. The three most significant phase bits give the octant. The remaining bits give the position inside that octant. In some octants that position is mirrored before it addresses the table. The two table values are then exchanged and negated as the octant requires, so that both outputs cover the whole circle.

The table contents come from a constant function at elaboration, so widths and depth follow the parameters. The block is a two-stage pipeline. A valid flag travels with each sample, and it is the only qualifier on the outputs. The outputs are recomputed on every cycle, whether or not the flag is set.

Top module: `sincos_octant_gen`

## Requirements
- R1: The phase `p` is PHASE_W bits wide, and 2^PHASE_W covers one turn. Each sample stands for the angle 2π(p+0.5)/2^PHASE_W, which is the centre of its phase bin. `sin_o` and `cos_o` are OUT_W-bit two's complement values, with amplitude A = 2^(OUT_W-1)-1. Each output lies within 1 LSB of A·sin and A·cos of that angle.
- R2: The octant index is `phase_i[PHASE_W-1:PHASE_W-3]`. In octant 0 both outputs are non-negative, and `sin_o` ≤ `cos_o`.
- R3: In octants 1, 2, 5 and 6, the table values are exchanged between the two outputs, so that |`sin_o`| ≥ |`cos_o`|. In octants 0, 3, 4 and 7, |`sin_o`| ≤ |`cos_o`|.
- R4: In odd octants, the table is addressed by the bitwise complement of the low PHASE_W-3 bits. As a result, for every p in octant 0, the phase 2^(PHASE_W-2)-1-p gives a `sin_o` exactly equal to the `cos_o` of p, and the reverse holds as well.
- R5: `sin_o` is negative exactly in octants 4 to 7. `cos_o` is negative exactly in octants 2 to 5.
- R6: A phase presented with `valid_i` before rising edge n appears on `sin_o` and `cos_o` after edge n+1. `valid_o` carries `valid_i` through the same two register stages.
- R7: While `rst_ni` is low, `valid_o`, `sin_o` and `cos_o` are all zero.
- R8: At every octant boundary (p = k·2^(PHASE_W-3) and p = k·2^(PHASE_W-3)-1, for all k) the R1 accuracy still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input phase is valid |
| phase_i | input | PHASE_W | Phase word, one turn = 2^PHASE_W |
| valid_o | output | 1 | Output samples are valid |
| sin_o | output | OUT_W | Signed sine sample |
| cos_o | output | OUT_W | Signed cosine sample |

## Verification
Every result is due two rising edges after the phase is presented. The first register stage holds the table read and the octant controls. The second holds the swap and sign stage. The bench drives inputs on falling edges and keeps a two-deep history of what it drove. At each falling edge it compares `valid_o`, `sin_o` and `cos_o` with the entry two steps back, so each check lines up with the exact cycle in which that result lands. A full sweep of every phase is recorded, and the exact mirror and sign relations are then checked across it. A randomized stream with gaps in `valid_i` exercises the latency of the valid flag.

// File: rtl/sc_fold_pkg.sv
package sc_fold_pkg;

  typedef struct packed {
    logic swap;
    logic neg_sin;
    logic neg_cos;
  } oct_ctl_t;

  localparam real PI_C = 3.14159265358979323846;

  // octant index -> exchange / sign controls
  function automatic oct_ctl_t decode_octant(input logic [2:0] oct);
    oct_ctl_t c;
    c.swap    = oct[0] ^ oct[1];
    c.neg_sin = oct[2];
    c.neg_cos = oct[1] ^ oct[2];
    return c;
  endfunction

  // first-octant table entry at bin centre, rounded
  function automatic int table_val(input int idx, input int addr_w,
                                   input int amp, input bit want_cos);
    real ang;
    real v;
    ang = (PI_C / 4.0) * (real'(idx) + 0.5) / (2.0 ** addr_w);
    v   = want_cos ? $cos(ang) : $sin(ang);
    return $rtoi(real'(amp) * v + 0.5);
  endfunction

endpackage

// File: rtl/sc_phase_fold.sv
module sc_phase_fold
  import sc_fold_pkg::*;
#(
  parameter int PHASE_W = 12,
  localparam int ADDR_W = PHASE_W - 3
) (
  input  logic [PHASE_W-1:0] phase_i,
  output logic [ADDR_W-1:0]  addr_o,
  output oct_ctl_t           ctl_o
);

  logic [2:0]        oct;
  logic [ADDR_W-1:0] low;

  assign oct = phase_i[PHASE_W-1 -: 3];
  assign low = phase_i[ADDR_W-1:0];

  always_comb begin
    // odd octants run backwards through the table
    addr_o = oct[0] ? ~low : low;
    ctl_o  = decode_octant(oct);
  end

endmodule

// File: rtl/sc_octant_rom.sv
module sc_octant_rom
  import sc_fold_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int OUT_W  = 12,
  localparam int DEPTH = 2 ** ADDR_W,
  localparam int AMP   = 2 ** (OUT_W - 1) - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic signed [OUT_W-1:0] sin_q_o,
  output logic signed [OUT_W-1:0] cos_q_o
);

  logic signed [OUT_W-1:0] rom_sin [DEPTH];
  logic signed [OUT_W-1:0] rom_cos [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tab
    assign rom_sin[i] = OUT_W'(table_val(i, ADDR_W, AMP, 1'b0));
    assign rom_cos[i] = OUT_W'(table_val(i, ADDR_W, AMP, 1'b1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_q_o <= '0;
      cos_q_o <= '0;
    end else begin
      sin_q_o <= rom_sin[addr_i];
      cos_q_o <= rom_cos[addr_i];
    end
  end

  // R2: first-octant table never has sin above cos, never negative
  a_r2_first_octant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sin_q_o >= 0) && (cos_q_o >= sin_q_o));

endmodule

// File: rtl/sc_sign_map.sv
module sc_sign_map
  import sc_fold_pkg::*;
#(
  parameter int OUT_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  oct_ctl_t                ctl_i,
  input  logic signed [OUT_W-1:0] sin_i,
  input  logic signed [OUT_W-1:0] cos_i,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o
);

  logic signed [OUT_W-1:0] sel_s, sel_c, sin_d, cos_d;

  always_comb begin
    sel_s = ctl_i.swap ? cos_i : sin_i;
    sel_c = ctl_i.swap ? sin_i : cos_i;
    sin_d = ctl_i.neg_sin ? -sel_s : sel_s;
    cos_d = ctl_i.neg_cos ? -sel_c : sel_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_o <= '0;
      cos_o <= '0;
    end else begin
      sin_o <= sin_d;
      cos_o <= cos_d;
    end
  end

  // R2: no exchange, no sign -> table values pass untouched
  a_r2_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i == '0) |=> (sin_o == $past(sin_i)) && (cos_o == $past(cos_i)));

  // R3: exchange only
  a_r3_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.swap && !ctl_i.neg_sin && !ctl_i.neg_cos)
      |=> (sin_o == $past(cos_i)) && (cos_o == $past(sin_i)));

  // R5: negated sine lands below zero
  a_r5_sin_negative: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.neg_sin && !ctl_i.swap && sin_i > 0) |=> (sin_o < 0));

  // R1: amplitude symmetric, most negative code never produced
  a_r1_no_min_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sin_o != {1'b1, {(OUT_W-1){1'b0}}}) && (cos_o != {1'b1, {(OUT_W-1){1'b0}}}));

endmodule

// File: rtl/sincos_octant_gen.sv
module sincos_octant_gen
  import sc_fold_pkg::*;
#(
  parameter int PHASE_W = 12,
  parameter int OUT_W   = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [PHASE_W-1:0]      phase_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o
);

  localparam int ADDR_W = PHASE_W - 3;

  logic [ADDR_W-1:0]       addr;
  oct_ctl_t                ctl_d, ctl_q;
  logic signed [OUT_W-1:0] tab_sin, tab_cos;
  logic                    vld_q;
  logic [1:0]              since_rst;

  sc_phase_fold #(.PHASE_W(PHASE_W)) u_fold (
    .phase_i (phase_i),
    .addr_o  (addr),
    .ctl_o   (ctl_d)
  );

  sc_octant_rom #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_rom (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr),
    .sin_q_o (tab_sin),
    .cos_q_o (tab_cos)
  );

  // controls ride alongside the table read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q     <= '0;
      vld_q     <= 1'b0;
      valid_o   <= 1'b0;
      since_rst <= '0;
    end else begin
      ctl_q     <= ctl_d;
      vld_q     <= valid_i;
      valid_o   <= vld_q;
      if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end
  end

  sc_sign_map #(.OUT_W(OUT_W)) u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl_q),
    .sin_i  (tab_sin),
    .cos_i  (tab_cos),
    .sin_o  (sin_o),
    .cos_o  (cos_o)
  );

  // R6: valid flag delayed by exactly two edges
  a_r6_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2) |-> (valid_o == $past(valid_i, 2)));

  // R5: sine sign follows phase msb two edges back (sine never zero at bin centres)
  a_r5_sin_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2) |-> (sin_o[OUT_W-1] == $past(phase_i[PHASE_W-1], 2)));

endmodule

// File: tb/sim_sincos_octant_gen.sv
`timescale 1ns/1ps
module sim_sincos_octant_gen;

  localparam int PW  = 12;
  localparam int OW  = 12;
  localparam int NPH = 2 ** PW;
  localparam int OCT = 2 ** (PW - 3);
  localparam int AMP = 2 ** (OW - 1) - 1;
  localparam real PI_R = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [PW-1:0] phase_i = '0;
  logic valid_o;
  logic signed [OW-1:0] sin_o, cos_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit hv1 = 0, hv2 = 0;
  int hp1 = 0, hp2 = 0;
  int obs_s [NPH];
  int obs_c [NPH];

  always #4 clk = ~clk;

  sincos_octant_gen #(.PHASE_W(PW), .OUT_W(OW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .phase_i(phase_i),
    .valid_o(valid_o), .sin_o(sin_o), .cos_o(cos_o)
  );

  function automatic int ref_val(input int p, input bit want_cos);
    real ang;
    ang = 2.0 * PI_R * (real'(p) + 0.5) / real'(NPH);
    return $rtoi($floor(real'(AMP) * (want_cos ? $cos(ang) : $sin(ang)) + 0.5));
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_sample(input int p, input bit bnd);
    int s, c, es, ec, oc;
    s = int'(sin_o); c = int'(cos_o);
    es = ref_val(p, 1'b0); ec = ref_val(p, 1'b1);
    oc = p / OCT;
    obs_s[p] = s; obs_c[p] = c;
    chk(iabs(s - es) <= 1, bnd ? "R8 sin" : "R1 sin", s, es);
    chk(iabs(c - ec) <= 1, bnd ? "R8 cos" : "R1 cos", c, ec);
    if (oc == 0) chk(s >= 0 && s <= c, "R2 octant0 order", s, c);
    if (oc == 1 || oc == 2 || oc == 5 || oc == 6)
      chk(iabs(s) >= iabs(c), "R3 swapped magnitude", s, c);
    else
      chk(iabs(s) <= iabs(c), "R3 direct magnitude", s, c);
    chk((s < 0) == (oc >= 4), "R5 sin sign", s, oc);
    chk((c < 0) == (oc >= 2 && oc <= 5), "R5 cos sign", c, oc);
  endtask

  task automatic step(input bit v, input int p, input bit bnd);
    @(negedge clk);
    chk(valid_o == hv2, "R6 valid latency", int'(valid_o), int'(hv2));
    if (hv2) check_sample(hp2, bnd);
    hv2 = hv1; hp2 = hp1;
    hv1 = v;   hp1 = p;
    valid_i = v;
    phase_i = PW'(p);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NPH; i++) begin obs_s[i] = 99999; obs_c[i] = 99999; end
    repeat (3) @(negedge clk);
    valid_i = 1'b1; phase_i = PW'(1000);
    @(negedge clk);
    chk(valid_o == 1'b0, "R7 valid in reset", int'(valid_o), 0);
    chk(sin_o == 0, "R7 sin in reset", int'(sin_o), 0);
    chk(cos_o == 0, "R7 cos in reset", int'(cos_o), 0);
    valid_i = 1'b0;
    rst_n = 1'b1;
    // R8: octant boundaries
    for (int k = 0; k < 8; k++) begin
      step(1'b1, k * OCT, 1'b1);
      step(1'b1, (k * OCT + NPH - 1) % NPH, 1'b1);
    end
    // full sweep
    for (int p = 0; p < NPH; p++) step(1'b1, p, 1'b0);
    step(1'b0, 0, 1'b0);
    step(1'b0, 0, 1'b0);
    // R4: mirror symmetry, exact
    for (int p = 0; p < OCT; p++) begin
      int q;
      q = 2 * OCT - 1 - p;
      chk(obs_s[q] == obs_c[p], "R4 mirror sin", obs_s[q], obs_c[p]);
      chk(obs_c[q] == obs_s[p], "R4 mirror cos", obs_c[q], obs_s[p]);
    end
    // random stream with valid gaps (R6)
    for (int i = 0; i < 3000; i++) begin
      int rp;
      bit rv;
      rp = int'($urandom_range(NPH - 1, 0));
      rv = ($urandom_range(3, 0) != 0);
      step(rv, rp, 1'b0);
    end
    step(1'b0, 0, 1'b0);
    step(1'b0, 0, 1'b0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule